// File: doc/BRIEF.md
# Clause-22 Management Slave

This block is the device side of a two-wire serial management link. Every bit is taken from the data line on the rising edge of the management clock. The block waits for a run of at least 32 one bits, a start pair, an operation code and two 5-bit addresses.

When the device address in a frame equals the value on the strap pins, the block acts on the frame:
- **Read:** it returns a stored 16-bit word through a tri-state output pair (value plus enable).
- **Write:** it stores the 16-bit word sent by the master into one of 32 internal registers.

A disable pin turns off all access. Two register fields are brought out as pins so that neighbouring logic can use them: all of register 0, and bit 11 of register 26, which asks for stronger output drivers.

Top module: `mgmt_slave`

## Requirements
- R1: After reset the output enable is low, every register holds 0, `ctrl_word` is 0 and `drive_boost` is 0.
- R2: A frame is recognised only after at least 32 consecutive ones followed by the start pair 0,1; a 0 after fewer than 32 ones is ignored and the count restarts.
- R3: Opcode 1,0 is a read and 0,1 is a write; opcodes 0,0 and 1,1 end the frame with no drive and no register change.
- R4: A frame whose 5-bit device address (sent MSB first, right after the opcode) differs from `phy_addr_strap` causes no drive and no register change.
- R5: On a read, the output enable stays low in the bit period after the last register-address bit, then goes high with value 0 for the following bit period.
- R6: After that zero, a read drives the addressed register's 16 bits MSB first, one per bit period, and then releases the line.
- R7: A write skips two turnaround bits, then captures 16 data bits MSB first into the register named by the 5-bit register address, sent MSB first; all 32 registers, including 31, can be written and read back.
- R8: While `mgmt_disable` is high, no frame is served: `mdio_oe` stays low and writes leave the registers unchanged.
- R9: `ctrl_word` always shows register 0 and `drive_boost` always shows bit 11 of register 26.
- R10: If the bit after the start 0 is not 1, the block returns to hunting for a run of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Value of the shared data line |
| mdio_out | output | 1 | Value the block drives when enabled |
| mdio_oe | output | 1 | Output enable for the data line |
| phy_addr_strap | input | 5 | Device address the block answers to |
| mgmt_disable | input | 1 | High blocks all reads and writes |
| drive_boost | output | 1 | Bit 11 of register 26 |
| ctrl_word | output | 16 | Contents of register 0 |

## Verification
Call E0 the rising edge at which the last register-address bit is sampled.

| Result | When it is due |
|---|---|
| Read: enable still low | after E0 |
| Read: turnaround zero on the line | after E1 |
| Read: data bit 15 | after E2 |
| Read: data bit 0 | after E17 |
| Read: line released | after E18 |
| Write: register updated, `ctrl_word` and `drive_boost` follow | at E18, 18 edges after E0 |

The bench drives the line at falling edges and samples at falling edges. Each observation therefore lands half a period after the edge that produced it. A monitor follows the read enable bit by bit and matches each read word against a queue that the driver fills. Ignored frames are checked by counting enable cycles over the whole response window.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  typedef enum logic [2:0] {
    S_HUNT,
    S_START1,
    S_OPCODE,
    S_ADDR,
    S_RD_TURN,
    S_RD_DATA,
    S_WR_TURN,
    S_WR_DATA
  } mgmt_state_t;

  function automatic logic op_is_read(input logic [1:0] op);
    return op == 2'b10;
  endfunction

  function automatic logic op_is_write(input logic [1:0] op);
    return op == 2'b01;
  endfunction

  function automatic logic op_is_valid(input logic [1:0] op);
    return op_is_read(op) || op_is_write(op);
  endfunction

  function automatic logic addr_hit(input logic [4:0] frame_addr,
                                    input logic [4:0] strap);
    return frame_addr == strap;
  endfunction

endpackage

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
  import mgmt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_in,
  input  logic [ADDR_W-1:0] strap,
  input  logic              disable_i,
  output logic              oe_q,
  output logic              out_q,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int HDR_W   = 2 + 2 * ADDR_W;
  localparam int PCNT_W  = $clog2(PRE_LEN + 1);
  localparam int BCNT_W  = $clog2(DATA_W + 1);
  localparam int RUN_W   = $clog2(DATA_W + 3);
  localparam logic [PCNT_W-1:0] PRE_FULL = PCNT_W'(PRE_LEN);
  localparam logic [BCNT_W-1:0] OP_LAST  = BCNT_W'(1);
  localparam logic [BCNT_W-1:0] AD_LAST  = BCNT_W'(2 * ADDR_W - 1);
  localparam logic [BCNT_W-1:0] TA_LAST  = BCNT_W'(1);
  localparam logic [BCNT_W-1:0] RD_END   = BCNT_W'(DATA_W);
  localparam logic [BCNT_W-1:0] WR_LAST  = BCNT_W'(DATA_W - 1);

  mgmt_state_t         state;
  logic [PCNT_W-1:0]   pre_cnt;
  logic [BCNT_W-1:0]   bit_cnt;
  logic [HDR_W-1:0]    hdr;
  logic [DATA_W-1:0]   shift_q;
  logic [ADDR_W-1:0]   reg_addr_q;

  logic [HDR_W-1:0]    hdr_next;
  logic [1:0]          frame_op;
  logic [ADDR_W-1:0]   frame_phy;
  logic [ADDR_W-1:0]   frame_reg;
  logic                pre_full;
  logic                hdr_done;
  logic                frame_accept;
  logic                wr_last_bit;

  assign hdr_next     = {hdr[HDR_W-2:0], mdio_in};
  assign frame_op     = hdr_next[HDR_W-1 -: 2];
  assign frame_phy    = hdr_next[2*ADDR_W-1 -: ADDR_W];
  assign frame_reg    = hdr_next[ADDR_W-1:0];
  assign pre_full     = pre_cnt == PRE_FULL;
  assign hdr_done     = (state == S_ADDR) && (bit_cnt == AD_LAST);
  assign frame_accept = hdr_done && addr_hit(frame_phy, strap) && !disable_i;
  assign wr_last_bit  = (state == S_WR_DATA) && (bit_cnt == WR_LAST);

  assign rd_addr = reg_addr_q;
  assign wr_addr = reg_addr_q;
  assign wr_data = {shift_q[DATA_W-2:0], mdio_in};
  assign wr_en   = wr_last_bit && !disable_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_HUNT;
      pre_cnt    <= '0;
      bit_cnt    <= '0;
      hdr        <= '0;
      shift_q    <= '0;
      reg_addr_q <= '0;
      oe_q       <= 1'b0;
      out_q      <= 1'b0;
    end else begin
      case (state)
        S_HUNT: begin
          if (mdio_in) begin
            if (!pre_full) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            if (pre_full) state <= S_START1;
            pre_cnt <= '0;
          end
        end
        S_START1: begin
          bit_cnt <= '0;
          state   <= mdio_in ? S_OPCODE : S_HUNT;
        end
        S_OPCODE: begin
          hdr     <= hdr_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == OP_LAST) begin
            bit_cnt <= '0;
            state   <= op_is_valid(hdr_next[1:0]) ? S_ADDR : S_HUNT;
          end
        end
        S_ADDR: begin
          hdr     <= hdr_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (hdr_done) begin
            bit_cnt    <= '0;
            reg_addr_q <= frame_reg;
            if (frame_accept)
              state <= op_is_read(frame_op) ? S_RD_TURN : S_WR_TURN;
            else
              state <= S_HUNT;
          end
        end
        S_RD_TURN: begin
          oe_q    <= 1'b1;
          out_q   <= 1'b0;
          shift_q <= rd_data;
          bit_cnt <= '0;
          state   <= S_RD_DATA;
        end
        S_RD_DATA: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == RD_END) begin
            oe_q  <= 1'b0;
            out_q <= 1'b0;
            state <= S_HUNT;
          end else begin
            out_q   <= shift_q[DATA_W-1];
            shift_q <= {shift_q[DATA_W-2:0], 1'b0};
          end
        end
        S_WR_TURN: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == TA_LAST) begin
            bit_cnt <= '0;
            state   <= S_WR_DATA;
          end
        end
        S_WR_DATA: begin
          shift_q <= wr_data;
          bit_cnt <= bit_cnt + 1'b1;
          if (wr_last_bit) state <= S_HUNT;
        end
        default: state <= S_HUNT;
      endcase
      if (state != S_HUNT) pre_cnt <= '0;
    end
  end

  logic [RUN_W-1:0] oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_run <= '0;
    else        oe_run <= oe_q ? oe_run + 1'b1 : '0;
  end

  assert_turn_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> (out_q == 1'b0));

  assert_drive_after_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> ($past(state) == S_RD_TURN));

  assert_drive_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (oe_run < RUN_W'(DATA_W + 1)));

  assert_start_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START1) |-> ($past(state) == S_HUNT));

endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int BOOST_REG = 26,
  parameter int BOOST_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] reg0,
  output logic              boost
);

  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  assign rd_data = regs[rd_addr];
  assign reg0    = regs[0];
  assign boost   = regs[BOOST_REG][BOOST_BIT];

  logic              wr_q;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      wr_q      <= wr_en;
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
  end

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (regs[last_addr] == last_data));

endmodule

// File: rtl/mgmt_slave.sv
module mgmt_slave #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  parameter int BOOST_REG = 26,
  parameter int BOOST_BIT = 11
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic [ADDR_W-1:0] phy_addr_strap,
  input  logic              mgmt_disable,
  output logic              drive_boost,
  output logic [DATA_W-1:0] ctrl_word
);

  logic              oe_q;
  logic              out_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  mgmt_frame_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRE_LEN(PRE_LEN)
  ) u_fsm (
    .clk      (mdc),
    .rst_n    (rst_n),
    .mdio_in  (mdio_in),
    .strap    (phy_addr_strap),
    .disable_i(mgmt_disable),
    .oe_q     (oe_q),
    .out_q    (out_q),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  mgmt_regfile #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BOOST_REG(BOOST_REG),
    .BOOST_BIT(BOOST_BIT)
  ) u_regs (
    .clk    (mdc),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .reg0   (ctrl_word),
    .boost  (drive_boost)
  );

  assign mdio_oe  = oe_q && !mgmt_disable;
  assign mdio_out = out_q;

  assert_write_blocked_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_en |-> !mgmt_disable);

endmodule

// File: tb/mgmt_slave_tb.sv
module mgmt_slave_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [4:0] MY_ADDR = 5'h0B;

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_in = 1'b1;
  logic        mdio_out;
  logic        mdio_oe;
  logic [4:0]  phy_addr_strap = MY_ADDR;
  logic        mgmt_disable = 1'b0;
  logic        drive_boost;
  logic [15:0] ctrl_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] exp_q [$];

  always #(CLK_PERIOD / 2) mdc = ~mdc;

  mgmt_slave u_dut (
    .mdc           (mdc),
    .rst_n         (rst_n),
    .mdio_in       (mdio_in),
    .mdio_out      (mdio_out),
    .mdio_oe       (mdio_oe),
    .phy_addr_strap(phy_addr_strap),
    .mgmt_disable  (mgmt_disable),
    .drive_boost   (drive_boost),
    .ctrl_word     (ctrl_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge mdc);
    mdio_in = b;
  endtask

  task automatic send_header(input int pre_n, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] rg);
    for (int i = 0; i < pre_n; i++) send_bit(1'b1);
    send_bit(st[1]); send_bit(st[0]);
    send_bit(op[1]); send_bit(op[0]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(rg[i]);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    send_header(32, 2'b01, 2'b01, phy, rg);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
  endtask

  // Sends a read-shaped frame and watches the 19-bit response window.
  task automatic do_read(input int pre_n, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] rg,
                         input bit respond, input logic [15:0] exp, input string req);
    int oe_cycles;
    oe_cycles = 0;
    send_header(pre_n, st, op, phy, rg);
    if (respond) exp_q.push_back(exp);
    for (int i = 0; i < 19; i++) begin
      @(negedge mdc);
      mdio_in = 1'b1;
      if (i == 0 && respond) check("R5 released in first turnaround bit", mdio_oe, 0);
      if (mdio_oe) oe_cycles++;
    end
    if (!respond) check(req, oe_cycles, 0);
  endtask

  // Scoreboard monitor: pops one expected word per served read.
  logic        prev_oe = 1'b0;
  int          collect = 0;
  bit          post = 0;
  logic [15:0] got;
  logic [15:0] want;
  always @(negedge mdc) begin
    if (rst_n) begin
      if (mdio_oe && !prev_oe) begin
        check("R5 turnaround zero", mdio_out, 0);
        if (exp_q.size() == 0) begin
          check("R4 unexpected drive", 1, 0);
        end else begin
          want    = exp_q.pop_front();
          collect = 16;
          got     = '0;
        end
      end else if (collect > 0) begin
        got = {got[14:0], mdio_out};
        if (!mdio_oe) check("R6 enable held during data", mdio_oe, 1);
        collect--;
        if (collect == 0) begin
          check("R6 read data MSB first", got, want);
          post = 1;
        end
      end else if (post) begin
        check("R6 line released after data", mdio_oe, 0);
        post = 0;
      end
    end
    prev_oe = mdio_oe;
  end

  initial begin
    repeat (200000) @(posedge mdc);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    check("R1 oe after reset", mdio_oe, 0);
    check("R1 ctrl_word after reset", ctrl_word, 0);
    check("R1 drive_boost after reset", drive_boost, 0);
    do_read(32, 2'b01, 2'b10, MY_ADDR, 5'd7, 1, 16'h0000, "R1");

    do_write(MY_ADDR, 5'd5, 16'hA5C3);
    do_read(32, 2'b01, 2'b10, MY_ADDR, 5'd5, 1, 16'hA5C3, "R7");

    do_write(MY_ADDR, 5'd0, 16'h1234);
    @(negedge mdc);
    check("R9 ctrl_word follows reg 0", ctrl_word, 16'h1234);

    do_write(MY_ADDR, 5'd26, 16'h0800);
    @(negedge mdc);
    check("R9 drive_boost set", drive_boost, 1);
    do_write(MY_ADDR, 5'd26, 16'hF7FF);
    @(negedge mdc);
    check("R9 drive_boost cleared", drive_boost, 0);
    do_read(32, 2'b01, 2'b10, MY_ADDR, 5'd26, 1, 16'hF7FF, "R7");

    do_write(MY_ADDR, 5'd31, 16'h8001);
    do_read(32, 2'b01, 2'b10, MY_ADDR, 5'd31, 1, 16'h8001, "R7");

    do_write(5'h0C, 5'd5, 16'hFFFF);
    do_read(32, 2'b01, 2'b10, MY_ADDR, 5'd5, 1, 16'hA5C3, "R4");
    do_read(32, 2'b01, 2'b10, 5'h0C, 5'd5, 0, 16'h0, "R4 mismatched address drove line");

    mgmt_disable = 1'b1;
    do_write(MY_ADDR, 5'd5, 16'h0F0F);
    do_read(32, 2'b01, 2'b10, MY_ADDR, 5'd5, 0, 16'h0, "R8 disabled read drove line");
    mgmt_disable = 1'b0;
    do_read(32, 2'b01, 2'b10, MY_ADDR, 5'd5, 1, 16'hA5C3, "R8");

    do_read(32, 2'b01, 2'b11, MY_ADDR, 5'd5, 0, 16'h0, "R3 opcode 11 drove line");
    do_read(32, 2'b01, 2'b00, MY_ADDR, 5'd5, 0, 16'h0, "R3 opcode 00 drove line");
    do_read(32, 2'b00, 2'b10, MY_ADDR, 5'd5, 0, 16'h0, "R10 bad start drove line");

    do_write(MY_ADDR, 5'd9, 16'h5555);
    do_read(31, 2'b01, 2'b10, MY_ADDR, 5'd9, 0, 16'h0, "R2 short preamble drove line");
    do_read(32, 2'b01, 2'b10, MY_ADDR, 5'd9, 1, 16'h5555, "R2");

    repeat (4) @(negedge mdc);
    check("R6 every expected read served", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule